// File: doc/BRIEF.md
# Link alarm aggregator

This block gathers the fault indications of a line interface into a small set of alarms and one interrupt pin. Raw fault flags from the transmit and receive paths are registered into two 16-bit status words. Some bits hold their value until software reads them (latch-high bits). The others follow their source one cycle late (level bits). A monitor flag from each direction, built from the threshold-comparator outputs under a software mask, goes into bit 1 of that direction's status word.

Each direction's status word, masked bit by bit with its own enable word, reduces to one alarm term. The three link-health inputs combine into a link-up indication. A small state machine detects every change of that indication and sets a latched link-change alarm. The link-change alarm, the two direction alarms and thirteen auxiliary flags form the interrupt status word. That word, masked by the interrupt enable word, drives the active-low interrupt pin.

The link state machine has three states. After reset it is in LNK_UNKNOWN. On its first sample it moves to LNK_UP or LNK_DOWN without raising an alarm. It moves from LNK_DOWN to LNK_UP when the link indication goes true, and from LNK_UP to LNK_DOWN when it goes false. Each of these two moves pulses the change alarm. Software reads a status word with a one-cycle read strobe. The value shown during that cycle is the pre-clear value.

Top module: `link_alarm_agg`

## Requirements
- R1: After reset, the enable words are tx_en_q = 0x0399, rx_en_q = 0x0039 and irq_en_q = 0x0000. Both masks are 0, all three status words are 0, link_up is 0 and irq_n is 1.
- R2: When wr_en is high, wr_sel picks the register written at the clock edge: 0 for tx_en, 1 for rx_en, 2 for irq_en, 3 for tx_mask (wr_data[5:0]) and 4 for rx_mask (wr_data[1:0]). Codes 5 to 7 change nothing. Without wr_en, all configuration outputs hold.
- R3: The latch-high bits are tx_stat bits 0, 3, 4 and 6, and rx_stat bits 0, 3, 4 and 5. Such a bit sets one cycle after its source is high and holds until read. Every other bit equals its source of the previous cycle.
- R4: A read strobe (rd_tx_stat, rd_rx_stat, rd_irq_stat) clears the latch-high bits of its word at that clock edge. A bit whose source is high in the same cycle stays set.
- R5: Bit 1 of the transmit source is tx_src[1] ORed with the OR of (tx_mon_flags AND tx_mask_q). The six monitor flags are bit 0 temperature high, bit 1 temperature low, bit 2 bias high, bit 3 bias low, bit 4 power high and bit 5 power low.
- R6: Bit 1 of the receive source is rx_src[1] ORed with the OR of (rx_mon_flags AND rx_mask_q). The receive flags are bit 0 power high and bit 1 power low.
- R7: The link is up when pmd_sig_det, pcs_blk_lock and xs_lane_align are all high. link_up shows the state one cycle later. Every change of the link between two samples sets irq_stat[0], which is latch-high and cleared by rd_irq_stat. The first sample after reset sets nothing.
- R8: irq_stat[1] is the OR of (tx_stat AND tx_en_q). irq_stat[2] is the OR of (rx_stat AND rx_en_q). irq_stat[15:3] equals aux_flags in the same cycle.
- R9: tx_alarm = irq_stat[1] AND irq_en_q[1]. rx_alarm = irq_stat[2] AND irq_en_q[2]. ls_alarm = irq_stat[0] AND irq_en_q[0].
- R10: irq_n is low exactly when (irq_stat AND irq_en_q) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_src | input | 16 | Transmit fault sources |
| rx_src | input | 16 | Receive fault sources |
| tx_mon_flags | input | 6 | Transmit monitor threshold flags |
| rx_mon_flags | input | 2 | Receive monitor threshold flags |
| aux_flags | input | 13 | Auxiliary interrupt status bits 15:3 |
| pmd_sig_det | input | 1 | Signal detect |
| pcs_blk_lock | input | 1 | Block lock |
| xs_lane_align | input | 1 | Lane alignment |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Configuration register select |
| wr_data | input | 16 | Configuration write data |
| rd_tx_stat | input | 1 | Read strobe, transmit status |
| rd_rx_stat | input | 1 | Read strobe, receive status |
| rd_irq_stat | input | 1 | Read strobe, interrupt status |
| tx_en_q | output | 16 | Transmit per-bit enables |
| rx_en_q | output | 16 | Receive per-bit enables |
| irq_en_q | output | 16 | Interrupt enables |
| tx_mask_q | output | 6 | Transmit monitor mask |
| rx_mask_q | output | 2 | Receive monitor mask |
| tx_stat | output | 16 | Transmit status word |
| rx_stat | output | 16 | Receive status word |
| irq_stat | output | 16 | Interrupt status word |
| link_up | output | 1 | Registered link indication |
| tx_alarm | output | 1 | Gated transmit alarm |
| rx_alarm | output | 1 | Gated receive alarm |
| ls_alarm | output | 1 | Gated link-change alarm |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a read strobe in the same cycle as a latch-high source that is still high, because the set must win over the clear. A close second is a link that is already up when reset ends, which must not count as a change. The bench holds all three link inputs high through reset and checks that no change alarm appears. It then runs a long random phase in which sparse fault sources, frequent read strobes, link toggles and configuration writes overlap freely. A behavioural model is compared against every output on every cycle, so each collision of read and set is checked.

// File: rtl/lka_pkg.sv
package lka_pkg;
    parameter int STAT_W   = 16;
    parameter int TX_MON_W = 6;
    parameter int RX_MON_W = 2;
    parameter int LS_BIT   = 0;
    parameter int TXA_BIT  = 1;
    parameter int RXA_BIT  = 2;
    parameter int MON_BIT  = 1;
    parameter int AUX_LO   = 3;

    localparam logic [STAT_W-1:0] TX_EN_RST = 16'h0399;
    localparam logic [STAT_W-1:0] RX_EN_RST = 16'h0039;
    localparam logic [STAT_W-1:0] TX_LH     = 16'h0059;
    localparam logic [STAT_W-1:0] RX_LH     = 16'h0039;

    typedef enum logic [2:0] {
        SEL_TX_EN   = 3'd0,
        SEL_RX_EN   = 3'd1,
        SEL_IRQ_EN  = 3'd2,
        SEL_TX_MASK = 3'd3,
        SEL_RX_MASK = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        LNK_UNKNOWN = 2'd0,
        LNK_DOWN    = 2'd1,
        LNK_UP      = 2'd2
    } link_state_e;
endpackage

// File: rtl/lka_status_bank.sv
module lka_status_bank #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   LH_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         rd,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        if (LH_MASK[i]) begin : g_lh
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src[i] | (bit_q & ~rd);
            end
        end else begin : g_lvl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src[i];
            end
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/lka_link_fsm.sv
module lka_link_fsm
    import lka_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    output logic link_up,
    output logic change
);
    link_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_UNKNOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        change  = 1'b0;
        unique case (state_q)
            LNK_UNKNOWN: state_d = link_in ? LNK_UP : LNK_DOWN;
            LNK_DOWN: if (link_in) begin
                state_d = LNK_UP;
                change  = 1'b1;
            end
            LNK_UP: if (!link_in) begin
                state_d = LNK_DOWN;
                change  = 1'b1;
            end
            default: state_d = LNK_UNKNOWN;
        endcase
    end

    assign link_up = (state_q == LNK_UP);
endmodule

// File: rtl/lka_cfg_regs.sv
module lka_cfg_regs
    import lka_pkg::*;
#(
    parameter int W   = STAT_W,
    parameter int TMW = TX_MON_W,
    parameter int RMW = RX_MON_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   tx_en,
    output logic [W-1:0]   rx_en,
    output logic [W-1:0]   irq_en,
    output logic [TMW-1:0] tx_mask,
    output logic [RMW-1:0] rx_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en   <= TX_EN_RST;
            rx_en   <= RX_EN_RST;
            irq_en  <= '0;
            tx_mask <= '0;
            rx_mask <= '0;
        end else if (wr_en) begin
            unique case (cfg_sel_e'(wr_sel))
                SEL_TX_EN:   tx_en   <= wr_data;
                SEL_RX_EN:   rx_en   <= wr_data;
                SEL_IRQ_EN:  irq_en  <= wr_data;
                SEL_TX_MASK: tx_mask <= wr_data[TMW-1:0];
                SEL_RX_MASK: rx_mask <= wr_data[RMW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/link_alarm_agg.sv
module link_alarm_agg
    import lka_pkg::*;
#(
    parameter int W   = STAT_W,
    parameter int TMW = TX_MON_W,
    parameter int RMW = RX_MON_W,
    localparam int AUX_W = W - AUX_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     tx_src,
    input  logic [W-1:0]     rx_src,
    input  logic [TMW-1:0]   tx_mon_flags,
    input  logic [RMW-1:0]   rx_mon_flags,
    input  logic [AUX_W-1:0] aux_flags,
    input  logic             pmd_sig_det,
    input  logic             pcs_blk_lock,
    input  logic             xs_lane_align,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_tx_stat,
    input  logic             rd_rx_stat,
    input  logic             rd_irq_stat,
    output logic [W-1:0]     tx_en_q,
    output logic [W-1:0]     rx_en_q,
    output logic [W-1:0]     irq_en_q,
    output logic [TMW-1:0]   tx_mask_q,
    output logic [RMW-1:0]   rx_mask_q,
    output logic [W-1:0]     tx_stat,
    output logic [W-1:0]     rx_stat,
    output logic [W-1:0]     irq_stat,
    output logic             link_up,
    output logic             tx_alarm,
    output logic             rx_alarm,
    output logic             ls_alarm,
    output logic             irq_n
);
    logic [W-1:0] tx_src_eff, rx_src_eff;
    logic         tx_mon, rx_mon, link_chg, ls_q;

    lka_cfg_regs #(.W(W), .TMW(TMW), .RMW(RMW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tx_en(tx_en_q), .rx_en(rx_en_q), .irq_en(irq_en_q),
        .tx_mask(tx_mask_q), .rx_mask(rx_mask_q)
    );

    assign tx_mon = |(tx_mon_flags & tx_mask_q);
    assign rx_mon = |(rx_mon_flags & rx_mask_q);

    always_comb begin
        tx_src_eff          = tx_src;
        tx_src_eff[MON_BIT] = tx_src[MON_BIT] | tx_mon;
        rx_src_eff          = rx_src;
        rx_src_eff[MON_BIT] = rx_src[MON_BIT] | rx_mon;
    end

    lka_status_bank #(.W(W), .LH_MASK(TX_LH)) u_tx_bank (
        .clk(clk), .rst_n(rst_n), .src(tx_src_eff), .rd(rd_tx_stat), .q(tx_stat)
    );
    lka_status_bank #(.W(W), .LH_MASK(RX_LH)) u_rx_bank (
        .clk(clk), .rst_n(rst_n), .src(rx_src_eff), .rd(rd_rx_stat), .q(rx_stat)
    );

    lka_link_fsm u_link (
        .clk(clk), .rst_n(rst_n),
        .link_in(pmd_sig_det & pcs_blk_lock & xs_lane_align),
        .link_up(link_up), .change(link_chg)
    );

    lka_status_bank #(.W(1), .LH_MASK(1'b1)) u_ls_bank (
        .clk(clk), .rst_n(rst_n), .src(link_chg), .rd(rd_irq_stat), .q(ls_q)
    );

    always_comb begin
        irq_stat                 = '0;
        irq_stat[LS_BIT]         = ls_q;
        irq_stat[TXA_BIT]        = |(tx_stat & tx_en_q);
        irq_stat[RXA_BIT]        = |(rx_stat & rx_en_q);
        irq_stat[W-1:AUX_LO]     = aux_flags;
    end

    assign tx_alarm = irq_stat[TXA_BIT] & irq_en_q[TXA_BIT];
    assign rx_alarm = irq_stat[RXA_BIT] & irq_en_q[RXA_BIT];
    assign ls_alarm = irq_stat[LS_BIT]  & irq_en_q[LS_BIT];
    assign irq_n    = ~|(irq_stat & irq_en_q);
endmodule

// File: rtl/lka_chk.sv
module lka_chk
    import lka_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] tx_src,
    input logic [15:0] tx_stat,
    input logic        rd_tx_stat,
    input logic [15:0] rx_src,
    input logic [1:0]  rx_mon_flags,
    input logic [15:0] rx_stat,
    input logic        rd_rx_stat,
    input logic        pmd_sig_det,
    input logic        pcs_blk_lock,
    input logic        xs_lane_align,
    input logic [15:0] irq_stat,
    input logic [15:0] irq_en_q,
    input logic        wr_en,
    input logic        tx_alarm,
    input logic        rx_alarm,
    input logic        ls_alarm,
    input logic        irq_n
);
    logic lnk;
    assign lnk = pmd_sig_det & pcs_blk_lock & xs_lane_align;

    assert_irq_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_alarm || rx_alarm || ls_alarm) |-> !irq_n);

    assert_ls_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ls_alarm |-> irq_stat[LS_BIT]);

    assert_lh_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_tx_stat |=> ((tx_stat & $past(tx_stat) & TX_LH) == ($past(tx_stat) & TX_LH)));

    assert_src_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_stat & $past(tx_src)) == $past(tx_src)));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx_stat && rx_src == 16'h0 && rx_mon_flags == 2'b00) |=> (rx_stat == 16'h0));

    assert_link_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[LS_BIT]) |-> ($past(lnk, 1) != $past(lnk, 2)));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq_en_q));
endmodule

bind link_alarm_agg lka_chk u_lka_chk (
    .clk(clk), .rst_n(rst_n), .tx_src(tx_src), .tx_stat(tx_stat), .rd_tx_stat(rd_tx_stat),
    .rx_src(rx_src), .rx_mon_flags(rx_mon_flags), .rx_stat(rx_stat), .rd_rx_stat(rd_rx_stat),
    .pmd_sig_det(pmd_sig_det), .pcs_blk_lock(pcs_blk_lock), .xs_lane_align(xs_lane_align),
    .irq_stat(irq_stat), .irq_en_q(irq_en_q), .wr_en(wr_en),
    .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .ls_alarm(ls_alarm), .irq_n(irq_n)
);

// File: tb/test_link_alarm_agg.sv
`timescale 1ns/1ps
module test_link_alarm_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_src = '0, rx_src = '0, wr_data = '0;
    logic [5:0]  tx_mon_flags = '0;
    logic [1:0]  rx_mon_flags = '0;
    logic [12:0] aux_flags = '0;
    logic        sd = 1'b1, bl = 1'b1, la = 1'b1;
    logic        wr_en = 1'b0, rd_tx = 1'b0, rd_rx = 1'b0, rd_irq = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] tx_en_q, rx_en_q, irq_en_q, tx_stat, rx_stat, irq_stat;
    logic [5:0]  tx_mask_q;
    logic [1:0]  rx_mask_q;
    logic        link_up, tx_alarm, rx_alarm, ls_alarm, irq_n;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_alarm_agg i_link_alarm_agg (
        .clk(clk), .rst_n(rst_n), .tx_src(tx_src), .rx_src(rx_src),
        .tx_mon_flags(tx_mon_flags), .rx_mon_flags(rx_mon_flags), .aux_flags(aux_flags),
        .pmd_sig_det(sd), .pcs_blk_lock(bl), .xs_lane_align(la),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_tx_stat(rd_tx), .rd_rx_stat(rd_rx), .rd_irq_stat(rd_irq),
        .tx_en_q(tx_en_q), .rx_en_q(rx_en_q), .irq_en_q(irq_en_q),
        .tx_mask_q(tx_mask_q), .rx_mask_q(rx_mask_q),
        .tx_stat(tx_stat), .rx_stat(rx_stat), .irq_stat(irq_stat), .link_up(link_up),
        .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .ls_alarm(ls_alarm), .irq_n(irq_n)
    );

    // Behavioural reference model
    logic [15:0] m_tx_en, m_rx_en, m_irq_en, m_tx, m_rx;
    logic [5:0]  m_tx_mask;
    logic [1:0]  m_rx_mask;
    logic        m_ls;
    int          m_prev;
    localparam logic [15:0] LH_T = 16'h0059, LH_R = 16'h0039;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tx_en = 16'h0399; m_rx_en = 16'h0039; m_irq_en = 0;
            m_tx_mask = 0; m_rx_mask = 0; m_tx = 0; m_rx = 0; m_ls = 0; m_prev = -1;
        end else begin
            logic [15:0] ts, rs;
            int cur;
            ts = tx_src; ts[1] = tx_src[1] | ((tx_mon_flags & m_tx_mask) != 0);
            rs = rx_src; rs[1] = rx_src[1] | ((rx_mon_flags & m_rx_mask) != 0);
            for (int i = 0; i < 16; i++) begin
                m_tx[i] = LH_T[i] ? (ts[i] | (m_tx[i] & !rd_tx)) : ts[i];
                m_rx[i] = LH_R[i] ? (rs[i] | (m_rx[i] & !rd_rx)) : rs[i];
            end
            cur = (sd && bl && la) ? 1 : 0;
            m_ls = ((m_prev >= 0) && (cur != m_prev)) || (m_ls && !rd_irq);
            m_prev = cur;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_tx_en = wr_data;
                    3'd1: m_rx_en = wr_data;
                    3'd2: m_irq_en = wr_data;
                    3'd3: m_tx_mask = wr_data[5:0];
                    3'd4: m_rx_mask = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_irq;
        e_irq = {aux_flags, (m_rx & m_rx_en) != 0, (m_tx & m_tx_en) != 0, m_ls};
        chk("R1/R2", "tx_en_q", tx_en_q, m_tx_en);
        chk("R1/R2", "rx_en_q", rx_en_q, m_rx_en);
        chk("R1/R2", "irq_en_q", irq_en_q, m_irq_en);
        chk("R2", "tx_mask_q", {10'd0, tx_mask_q}, {10'd0, m_tx_mask});
        chk("R2", "rx_mask_q", {14'd0, rx_mask_q}, {14'd0, m_rx_mask});
        chk("R3/R4/R5", "tx_stat", tx_stat, m_tx);
        chk("R3/R4/R6", "rx_stat", rx_stat, m_rx);
        chk("R7/R8", "irq_stat", irq_stat, e_irq);
        chk("R7", "link_up", {15'd0, link_up}, {15'd0, m_prev == 1});
        chk("R9", "tx_alarm", {15'd0, tx_alarm}, {15'd0, e_irq[1] & m_irq_en[1]});
        chk("R9", "rx_alarm", {15'd0, rx_alarm}, {15'd0, e_irq[2] & m_irq_en[2]});
        chk("R9", "ls_alarm", {15'd0, ls_alarm}, {15'd0, e_irq[0] & m_irq_en[0]});
        chk("R10", "irq_n", {15'd0, irq_n}, {15'd0, (e_irq & m_irq_en) == 0});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [2:0] sel, logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();
        chk("R1", "reset tx_en", tx_en_q, 16'h0399);
        chk("R1", "reset rx_en", rx_en_q, 16'h0039);
        chk("R1", "reset irq_n", {15'd0, irq_n}, 16'h0001);
        rst_n = 1'b1;
        repeat (4) tick();
        // R7: link already up at the first sample must not raise a change
        chk("R7", "no first-sample alarm", irq_stat, 16'h0000);
        chk("R7", "link_up after reset", {15'd0, link_up}, 16'h0001);
        wr(3'd2, 16'hFFFF);
        sd = 1'b0; tick();
        chk("R7", "change latched", {15'd0, irq_stat[0]}, 16'h0001);
        chk("R10", "irq pin low", {15'd0, irq_n}, 16'h0000);
        sd = 1'b1; tick(); tick();
        rd_irq = 1'b1; tick(); rd_irq = 1'b0; tick();
        chk("R4", "link alarm cleared", {15'd0, irq_stat[0]}, 16'h0000);
        // R3/R4 latch-high bit 0 and level bit 7
        tx_src = 16'h0081; tick(); tx_src = 16'h0000; tick();
        chk("R3", "lh bit held", tx_stat, 16'h0001);
        tx_src = 16'h0001; rd_tx = 1'b1; tick(); rd_tx = 1'b0; tx_src = 0; tick();
        chk("R4", "set wins over read", tx_stat, 16'h0001);
        rd_tx = 1'b1; tick(); rd_tx = 1'b0; tick();
        chk("R4", "read clears", tx_stat, 16'h0000);
        // R5/R6 monitor masks
        tx_mon_flags = 6'b100000; tick();
        chk("R5", "masked off", tx_stat, 16'h0000);
        wr(3'd3, 16'h0020); tick();
        chk("R5", "mask on", tx_stat, 16'h0002);
        tx_mon_flags = 0; rx_mon_flags = 2'b01; wr(3'd4, 16'h0001); tick();
        chk("R6", "rx mon", rx_stat, 16'h0002);
        rx_mon_flags = 0; wr(3'd6, 16'h1234); tick();
        aux_flags = 13'h1001; tick(); aux_flags = 0;
        // Random overlap phase
        for (int n = 0; n < 4000; n++) begin
            tx_src = 16'($urandom & $urandom & $urandom);
            rx_src = 16'($urandom & $urandom & $urandom);
            tx_mon_flags = 6'($urandom & $urandom);
            rx_mon_flags = 2'($urandom & $urandom);
            aux_flags = 13'($urandom & $urandom & $urandom & $urandom);
            if ($urandom % 6 == 0) sd = ~sd;
            if ($urandom % 9 == 0) bl = ~bl;
            if ($urandom % 11 == 0) la = ~la;
            rd_tx = ($urandom % 4 == 0);
            rd_rx = ($urandom % 4 == 0);
            rd_irq = ($urandom % 4 == 0);
            wr_en = ($urandom % 12 == 0);
            wr_sel = 3'($urandom);
            wr_data = 16'($urandom);
            tick();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule